// File: doc/BRIEF.md
# Bluetooth FEC Codec

The codec handles both forward error correction schemes of the Bluetooth baseband on one serial bit path. Each block carries a mode select (repetition or shortened Hamming) and a direction select (encode or decode). In repetition mode the encoder emits every data bit three times. The decoder reduces each triple to one bit by majority vote. In Hamming mode the encoder turns 10 information bits into a systematic 15-bit codeword. The decoder locates and repairs any single flipped bit in a received codeword, and reports an uncorrectable word when the syndrome matches no single position.

Bits enter and leave least significant bit first, one per clock, under valid/ready handshakes. The block works on one block at a time. It gathers the input bits of a block, spends one clock on the arithmetic, and then offers the result bits until the consumer has taken all of them. Only after that does it accept the next block. Two status flags travel with the output bits of each block: one says a correction was made, the other says the word could not be repaired.

Top module: `fecCodec`

## Requirements
- R1: After reset, inReady is 1 and outValid, corrected and uncorrectable are 0.
- R2: An input bit is taken on a rising edge where inValid and inReady are both 1. inReady stays 0 from the edge that takes the last input bit of a block until the edge that takes that block's last output bit. While outValid is 1 and outReady is 0, outValid, outBit and both flags hold their values.
- R3: hamSel (1 = Hamming, 0 = repetition) and decSel (1 = decode, 0 = encode) are sampled only together with the first input bit of a block. Changing them on later bits of the same block has no effect on that block's length or result.
- R4: Repetition encode takes 1 input bit and emits that bit 3 times.
- R5: Repetition decode takes 3 bits and emits 1 bit, which is 1 when at least two inputs are 1. corrected is 1 when the three bits are not all equal. uncorrectable is always 0.
- R6: Hamming encode takes info bits i0..i9 and emits 15 bits c0..c14. c5..c14 equal i0..i9. c0..c4 are the coefficients of D^0..D^4 in the remainder of i(D)·D^5 divided by D^5+D^4+D^2+1. c0 is sent first.
- R7: Hamming decode of a 15-bit word with zero remainder emits c5..c14 (10 bits) with both flags 0.
- R8: Hamming decode of a valid codeword with any one of its 15 bits inverted emits the original info bits, with corrected 1 and uncorrectable 0.
- R9: Hamming decode of a valid codeword with any two bits inverted sets uncorrectable to 1 and corrected to 0, and emits the received bits c5..c14 unchanged.
- R10: If the last input bit of a block is taken on edge k, outValid is 0 after edge k and 1 after edge k+1. Both flags read 0 whenever outValid is 0.
- R11: In either encode mode both flags stay 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| hamSel | input | 1 | 1 = Hamming code, 0 = repetition code; taken with a block's first bit |
| decSel | input | 1 | 1 = decode, 0 = encode; taken with a block's first bit |
| inValid | input | 1 | Input bit present |
| inReady | output | 1 | Codec can take an input bit |
| inBit | input | 1 | Serial input bit, LSB first |
| outValid | output | 1 | Output bit present |
| outReady | input | 1 | Consumer takes the output bit |
| outBit | output | 1 | Serial output bit, LSB first |
| corrected | output | 1 | The current output block was repaired |
| uncorrectable | output | 1 | The current Hamming word could not be repaired |

## Verification
Once the last input bit of a block is taken, the bench expects one idle cycle and then the first result bit. It looks at the sample point after that edge, where outValid must still be low, and at the sample point after the next edge, where it must be high. Outputs are sampled on falling edges, and each result bit is taken on the edge that the bench itself enables with outReady. Some bits are held back for one cycle to confirm that the value stays put. The flags are read with the first result bit, and they are read again once the block has drained, when they must have dropped.

// File: rtl/fecPkg.sv
package fecPkg;

  parameter int INFO_BITS = 10;
  parameter int PAR_BITS  = 5;
  parameter int REP_COUNT = 3;
  // lower coefficients of the generator (D^5 term implied): D^4 + D^2 + 1
  parameter logic [PAR_BITS-1:0] GEN_TAPS = 5'b10101;

  localparam int CW_BITS = INFO_BITS + PAR_BITS;
  localparam int CNT_W   = $clog2(CW_BITS + 1);

  typedef enum logic [1:0] {
    ST_FILL  = 2'd0,
    ST_CALC  = 2'd1,
    ST_DRAIN = 2'd2
  } fecState_t;

  typedef struct packed {
    logic capture;   // store inBit at capIdx
    logic cfgLoad;   // first bit of a block: latch mode and direction
    logic compute;   // one-cycle arithmetic step
    logic shiftOut;  // consumer took outBit
  } fecStrobe_t;

  // Remainder of word(D) divided by the generator, processed MSB first
  function automatic logic [PAR_BITS-1:0] polyRem(input logic [CW_BITS-1:0] word);
    logic [PAR_BITS-1:0] rem;
    logic top;
    rem = '0;
    for (int i = CW_BITS - 1; i >= 0; i--) begin
      top = rem[PAR_BITS-1];
      rem = {rem[PAR_BITS-2:0], word[i]};
      if (top) rem = rem ^ GEN_TAPS;
    end
    return rem;
  endfunction

endpackage

// File: rtl/fecHamming.sv
module fecHamming
  import fecPkg::*;
(
  input  logic [INFO_BITS-1:0] infoIn,
  input  logic [CW_BITS-1:0]   rxWord,
  output logic [CW_BITS-1:0]   encWord,
  output logic [INFO_BITS-1:0] decInfo,
  output logic                 fixedOne,
  output logic                 badWord
);

  logic [PAR_BITS-1:0] parity;
  logic [PAR_BITS-1:0] syndrome;
  logic [CW_BITS-1:0]  flipMask;
  logic [CW_BITS-1:0]  repaired;

  assign parity   = polyRem({infoIn, {PAR_BITS{1'b0}}});
  assign encWord  = {infoIn, parity};
  assign syndrome = polyRem(rxWord);

  // one comparator per bit position against that position's fixed syndrome
  for (genvar j = 0; j < CW_BITS; j++) begin : g_pos
    localparam logic [PAR_BITS-1:0] POS_SYN = polyRem(CW_BITS'(1) << j);
    assign flipMask[j] = (syndrome == POS_SYN);
  end

  assign fixedOne = |flipMask;
  assign badWord  = (syndrome != '0) && !fixedOne;
  assign repaired = rxWord ^ flipMask;
  assign decInfo  = repaired[CW_BITS-1:PAR_BITS];

endmodule

// File: rtl/fecCtrl.sv
module fecCtrl
  import fecPkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             inValid,
  input  logic             outReady,
  input  logic             hamSel,
  input  logic             decSel,
  output logic             inReady,
  output logic             outValid,
  output logic             cfgHam,
  output logic             cfgDec,
  output logic [CNT_W-1:0] capIdx,
  output fecStrobe_t       strb
);

  localparam logic [CNT_W-1:0] LEN_ONE  = CNT_W'(1);
  localparam logic [CNT_W-1:0] LEN_REP  = CNT_W'(REP_COUNT);
  localparam logic [CNT_W-1:0] LEN_INFO = CNT_W'(INFO_BITS);
  localparam logic [CNT_W-1:0] LEN_CW   = CNT_W'(CW_BITS);

  fecState_t        state;
  logic [CNT_W-1:0] inCnt;
  logic [CNT_W-1:0] outCnt;
  logic             useHam;
  logic             useDec;
  logic [CNT_W-1:0] inLen;
  logic [CNT_W-1:0] outLen;
  logic             lastIn;
  logic             lastOut;

  always_comb begin
    useHam = (inCnt == '0) ? hamSel : cfgHam;
    useDec = (inCnt == '0) ? decSel : cfgDec;
    if (useHam) inLen = useDec ? LEN_CW : LEN_INFO;
    else        inLen = useDec ? LEN_REP : LEN_ONE;
    if (cfgHam) outLen = cfgDec ? LEN_INFO : LEN_CW;
    else        outLen = cfgDec ? LEN_ONE : LEN_REP;
  end

  assign inReady       = (state == ST_FILL);
  assign outValid      = (state == ST_DRAIN);
  assign strb.capture  = inReady && inValid;
  assign strb.cfgLoad  = strb.capture && (inCnt == '0);
  assign strb.compute  = (state == ST_CALC);
  assign strb.shiftOut = outValid && outReady;
  assign capIdx        = inCnt;
  assign lastIn        = (inCnt == inLen - LEN_ONE);
  assign lastOut       = (outCnt == outLen - LEN_ONE);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state  <= ST_FILL;
      inCnt  <= '0;
      outCnt <= '0;
      cfgHam <= 1'b0;
      cfgDec <= 1'b0;
    end else begin
      case (state)
        ST_FILL: begin
          if (strb.capture) begin
            if (strb.cfgLoad) begin
              cfgHam <= hamSel;
              cfgDec <= decSel;
            end
            if (lastIn) begin
              inCnt <= '0;
              state <= ST_CALC;
            end else begin
              inCnt <= inCnt + LEN_ONE;
            end
          end
        end
        ST_CALC: begin
          outCnt <= '0;
          state  <= ST_DRAIN;
        end
        ST_DRAIN: begin
          if (strb.shiftOut) begin
            if (lastOut) begin
              outCnt <= '0;
              state  <= ST_FILL;
            end else begin
              outCnt <= outCnt + LEN_ONE;
            end
          end
        end
        default: state <= ST_FILL;
      endcase
    end
  end

  AST_RESULT_LATENCY: assert property (@(posedge clk) disable iff (!rstN)
    strb.capture && lastIn |=> !outValid && !inReady ##1 outValid); // R10

  AST_NO_INPUT_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    strb.capture && lastIn |=> !inReady); // R2

endmodule

// File: rtl/fecPath.sv
module fecPath
  import fecPkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  fecStrobe_t       strb,
  input  logic [CNT_W-1:0] capIdx,
  input  logic             inBit,
  input  logic             cfgHam,
  input  logic             cfgDec,
  output logic             outBit,
  output logic             corrFlag,
  output logic             uncFlag
);

  localparam int HALF_REP = REP_COUNT / 2;

  logic [CW_BITS-1:0]   inSr;
  logic [CW_BITS-1:0]   outSr;
  logic [CW_BITS-1:0]   nextOut;
  logic                 nextCorr;
  logic                 nextUnc;
  logic [CW_BITS-1:0]   encWord;
  logic [INFO_BITS-1:0] decInfo;
  logic                 fixedOne;
  logic                 badWord;
  logic                 repVote;
  logic                 repSplit;
  logic [REP_COUNT-1:0] repBits;

  fecHamming u_ham (
    .infoIn   (inSr[INFO_BITS-1:0]),
    .rxWord   (inSr),
    .encWord  (encWord),
    .decInfo  (decInfo),
    .fixedOne (fixedOne),
    .badWord  (badWord)
  );

  assign repBits  = inSr[REP_COUNT-1:0];
  assign repVote  = ($countones(repBits) > HALF_REP);
  assign repSplit = (repBits != '0) && (repBits != '1);

  always_comb begin
    nextOut  = '0;
    nextCorr = 1'b0;
    nextUnc  = 1'b0;
    case ({cfgHam, cfgDec})
      2'b00: nextOut = {{(CW_BITS-REP_COUNT){1'b0}}, {REP_COUNT{inSr[0]}}};
      2'b01: begin
        nextOut  = {{(CW_BITS-1){1'b0}}, repVote};
        nextCorr = repSplit;
      end
      2'b10: nextOut = encWord;
      default: begin
        nextOut  = {{PAR_BITS{1'b0}}, decInfo};
        nextCorr = fixedOne;
        nextUnc  = badWord;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      inSr     <= '0;
      outSr    <= '0;
      corrFlag <= 1'b0;
      uncFlag  <= 1'b0;
    end else begin
      if (strb.capture) inSr[capIdx] <= inBit;
      if (strb.compute) begin
        outSr    <= nextOut;
        corrFlag <= nextCorr;
        uncFlag  <= nextUnc;
      end else if (strb.shiftOut) begin
        outSr <= outSr >> 1;
      end
    end
  end

  assign outBit = outSr[0];

  AST_FLAGS_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rstN)
    !(corrFlag && uncFlag)); // R9

  AST_ENCODE_NO_FLAGS: assert property (@(posedge clk) disable iff (!rstN)
    strb.compute && !cfgDec |=> !corrFlag && !uncFlag); // R11

  AST_REP_NEVER_UNCORR: assert property (@(posedge clk) disable iff (!rstN)
    strb.compute && !cfgHam |=> !uncFlag); // R5

  AST_ENC_IS_CODEWORD: assert property (@(posedge clk) disable iff (!rstN)
    strb.compute && cfgHam && !cfgDec |=> polyRem(outSr) == '0); // R6

endmodule

// File: rtl/fecCodec.sv
module fecCodec
  import fecPkg::*;
(
  input  logic clk,
  input  logic rstN,
  input  logic hamSel,
  input  logic decSel,
  input  logic inValid,
  output logic inReady,
  input  logic inBit,
  output logic outValid,
  input  logic outReady,
  output logic outBit,
  output logic corrected,
  output logic uncorrectable
);

  fecStrobe_t       strb;
  logic [CNT_W-1:0] capIdx;
  logic             cfgHam;
  logic             cfgDec;
  logic             corrFlag;
  logic             uncFlag;

  fecCtrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .inValid  (inValid),
    .outReady (outReady),
    .hamSel   (hamSel),
    .decSel   (decSel),
    .inReady  (inReady),
    .outValid (outValid),
    .cfgHam   (cfgHam),
    .cfgDec   (cfgDec),
    .capIdx   (capIdx),
    .strb     (strb)
  );

  fecPath u_path (
    .clk      (clk),
    .rstN     (rstN),
    .strb     (strb),
    .capIdx   (capIdx),
    .inBit    (inBit),
    .cfgHam   (cfgHam),
    .cfgDec   (cfgDec),
    .outBit   (outBit),
    .corrFlag (corrFlag),
    .uncFlag  (uncFlag)
  );

  assign corrected     = corrFlag && outValid;
  assign uncorrectable = uncFlag && outValid;

  AST_OUTPUT_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    outValid && !outReady |=> outValid && $stable(outBit) && $stable(corrected)
                              && $stable(uncorrectable)); // R2

endmodule

// File: tb/fecCodec_tb.sv
module fecCodec_tb;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic hamSel = 1'b0;
  logic decSel = 1'b0;
  logic inValid = 1'b0;
  logic inBit = 1'b0;
  logic outReady = 1'b0;
  logic inReady, outValid, outBit, corrected, uncorrectable;

  int nChecks = 0;
  int nFail = 0;

  always #5 clk = ~clk;

  fecCodec u_dut (
    .clk           (clk),
    .rstN          (rstN),
    .hamSel        (hamSel),
    .decSel        (decSel),
    .inValid       (inValid),
    .inReady       (inReady),
    .inBit         (inBit),
    .outValid      (outValid),
    .outReady      (outReady),
    .outBit        (outBit),
    .corrected     (corrected),
    .uncorrectable (uncorrectable)
  );

  task automatic chk(input string req, input int act, input int exp);
    nChecks++;
    if (act != exp) begin
      nFail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // parity = sum of info bits times D^(i+5) mod g, stepping powers of D
  function automatic logic [4:0] benchParity(input logic [9:0] info);
    logic [4:0] acc;
    logic [4:0] pw;
    acc = 5'b0;
    pw  = 5'b10101; // D^5 reduced
    for (int i = 0; i < 10; i++) begin
      if (info[i]) acc = acc ^ pw;
      pw = pw[4] ? ({pw[3:0], 1'b0} ^ 5'b10101) : {pw[3:0], 1'b0};
    end
    return acc;
  endfunction

  task automatic runBlock(input bit dec, input bit ham, input logic [14:0] word,
                          input int nIn, input int nOut, input bit stall,
                          input bit flipMode, output logic [14:0] got,
                          output bit gotC, output bit gotU);
    logic holdBit;
    for (int i = 0; i < nIn; i++) begin
      @(negedge clk);
      chk("R2 inReady during fill", inReady, 1);
      inValid = 1'b1;
      inBit   = word[i];
      if (i == 0 || !flipMode) begin
        hamSel = ham; decSel = dec;
      end else begin
        hamSel = !ham; decSel = !dec; // R3: must be ignored
      end
      @(posedge clk);
    end
    @(negedge clk);
    inValid = 1'b0;
    chk("R10 idle cycle outValid", outValid, 0);
    chk("R2 inReady busy", inReady, 0);
    @(negedge clk);
    chk("R10 first result outValid", outValid, 1);
    got = '0; gotC = 1'b0; gotU = 1'b0;
    for (int j = 0; j < nOut; j++) begin
      if (stall && (j % 3 == 1)) begin
        outReady = 1'b0;
        holdBit = outBit;
        @(negedge clk);
        chk("R2 held outValid", outValid, 1);
        chk("R2 held outBit", outBit, holdBit);
      end
      chk("R2 outValid in drain", outValid, 1);
      chk("R2 inReady low in drain", inReady, 0);
      outReady = 1'b1;
      got[j] = outBit;
      if (j == 0) begin
        gotC = corrected; gotU = uncorrectable;
      end
      @(posedge clk);
      @(negedge clk);
      outReady = 1'b0;
    end
    chk("R10 outValid after drain", outValid, 0);
    chk("R10 flags after drain", {corrected, uncorrectable}, 0);
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    nFail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
    $finish;
  end

  initial begin : stim
    logic [14:0] got;
    logic [14:0] cw;
    logic [14:0] rx;
    logic [9:0]  info;
    bit c, u;

    repeat (3) @(negedge clk);
    chk("R1 reset inReady", inReady, 1);
    chk("R1 reset outValid", outValid, 0);
    chk("R1 reset flags", {corrected, uncorrectable}, 0);
    rstN = 1'b1;
    @(negedge clk);

    // R4 repetition encode
    for (int b = 0; b < 2; b++) begin
      runBlock(1'b0, 1'b0, 15'(b), 1, 3, b == 1, 1'b0, got, c, u);
      chk("R4 repeated bits", got, (b == 1) ? 7 : 0);
      chk("R11 rep encode flags", {c, u}, 0);
    end

    // R5 repetition decode, all triples
    for (int t = 0; t < 8; t++) begin
      runBlock(1'b1, 1'b0, 15'(t), 3, 1, 1'b0, 1'b0, got, c, u);
      chk("R5 majority", got, ($countones(3'(t)) >= 2) ? 1 : 0);
      chk("R5 corrected", c, (t != 0 && t != 7) ? 1 : 0);
      chk("R5 uncorrectable", u, 0);
    end

    // R6 Hamming encode, every info word
    for (int w = 0; w < 1024; w++) begin
      info = 10'(w);
      runBlock(1'b0, 1'b1, {5'b0, info}, 10, 15, (w % 37) == 0, 1'b0, got, c, u);
      chk("R6 codeword", got, {info, benchParity(info)});
      chk("R11 ham encode flags", {c, u}, 0);
    end

    // R7 clean and R8 single-error decode
    for (int w = 0; w < 64; w++) begin
      info = 10'((w * 331 + 5) & 10'h3ff);
      cw = {info, benchParity(info)};
      for (int e = -1; e < 15; e++) begin
        rx = (e >= 0) ? (cw ^ (15'(1) << e)) : cw;
        runBlock(1'b1, 1'b1, rx, 15, 10, (w % 11) == 0, 1'b0, got, c, u);
        if (e < 0) begin
          chk("R7 clean info", got, info);
          chk("R7 clean flags", {c, u}, 0);
        end else begin
          chk("R8 repaired info", got, info);
          chk("R8 corrected", c, 1);
          chk("R8 uncorrectable", u, 0);
        end
      end
    end

    // R9 double errors
    for (int w = 0; w < 4; w++) begin
      info = 10'(w * 257 + 99);
      cw = {info, benchParity(info)};
      for (int a = 0; a < 15; a++) begin
        for (int b = a + 1; b < 15; b++) begin
          rx = cw ^ (15'(1) << a) ^ (15'(1) << b);
          runBlock(1'b1, 1'b1, rx, 15, 10, 1'b0, 1'b0, got, c, u);
          chk("R9 passthrough", got, rx[14:5]);
          chk("R9 flags", {c, u}, 2'b01);
        end
      end
    end

    // R3 mode changes after the first bit are ignored
    info = 10'h2c9;
    runBlock(1'b0, 1'b1, {5'b0, info}, 10, 15, 1'b1, 1'b1, got, c, u);
    chk("R3 ham encode kept", got, {info, benchParity(info)});
    runBlock(1'b1, 1'b0, 15'b110, 3, 1, 1'b0, 1'b1, got, c, u);
    chk("R3 rep decode kept", got, 1);
    chk("R3 rep decode corrected", c, 1);

    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
    $finish;
  end

endmodule